// File: doc/BRIEF.md
# Nonce-Keyed Address Permuter

This block turns a linear memory address into a physical address through a few rounds of a small substitution/permutation network. Each round takes its own slice of a runtime nonce as a tweak, so reloading the nonce gives a different mapping of the address space without any change to the logic. Every round is invertible, so the whole map is a bijection over all `DEPTH` addresses. Two different logical addresses can never land on the same physical word.

A controller places the block in front of the memory's address port. The plain address comes out beside the scrambled one, delayed by the same cycle, so that error reports always carry the address the requester used. The inverse input runs the rounds backwards. Verification and debug use it to recover a logical address from a physical one. With the round count set to zero the block passes addresses through unchanged.

Top module: `addr_scrambler`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_o` and `plain_addr_o` both become zero at that edge.
- R2: `addr_o` reflects `addr_i`, `nonce_i` and `inverse_i` as sampled at the previous rising edge (one register stage). Identical inputs always give an identical result.
- R3: With `ROUNDS` > 0, `inverse_i` = 0 and a fixed nonce, the `DEPTH` addresses map to `DEPTH` distinct values of `addr_o`.
- R4: Two nonces that differ in the slice used by the first round (bits `[AW-1:0]`) give different mappings.
- R5: With the same nonce, driving the forward result back in with `inverse_i` = 1 returns the original address.
- R6: With `ROUNDS` = 0, `addr_o` equals the address sampled one edge earlier, whatever `nonce_i` and `inverse_i` are.
- R7: `plain_addr_o` always equals `addr_i` from the previous edge, independent of the nonce and the mode.
- R8: Round r takes its tweak from nonce bits `[r*AW +: AW]`. Two nonces that differ only in the last round's slice therefore still give different mappings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Logical address (AW = log2 DEPTH) |
| nonce_i | input | NW | Tweak bits, AW per round (NW = max(ROUNDS,1)*AW) |
| inverse_i | input | 1 | 1 runs the rounds backwards |
| addr_o | output | AW | Registered scrambled (or unscrambled) address |
| plain_addr_o | output | AW | Registered copy of the unscrambled input address |

## Verification
The property that is hardest to show from the ports is that the map is a bijection. A single sample says nothing about it; the bench has to see every output of a full address space under one nonce. The bench therefore uses a small depth and sweeps every address under several nonces. It marks each output in a seen-table and then replays each output in inverse mode to get the start address back. For nonce sensitivity it compares full maps from nonce pairs that differ in only one round's slice. Those pairs are chosen so that a difference is guaranteed.

// File: rtl/addr_scr_pkg.sv
package addr_scr_pkg;

  // Invertible 4-bit substitution
  function automatic logic [3:0] sbox4(input logic [3:0] v);
    logic [3:0] r;
    case (v)
      4'h0: r = 4'hC;  4'h1: r = 4'h5;  4'h2: r = 4'h6;  4'h3: r = 4'hB;
      4'h4: r = 4'h9;  4'h5: r = 4'h0;  4'h6: r = 4'hA;  4'h7: r = 4'hD;
      4'h8: r = 4'h3;  4'h9: r = 4'hE;  4'hA: r = 4'hF;  4'hB: r = 4'h8;
      4'hC: r = 4'h4;  4'hD: r = 4'h7;  4'hE: r = 4'h1;  default: r = 4'h2;
    endcase
    return r;
  endfunction

  // Inverse is derived by search so the two can never drift apart
  function automatic logic [3:0] sbox4_inv(input logic [3:0] v);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (sbox4(4'(i)) == v) r = 4'(i);
    end
    return r;
  endfunction

  // Destination bit position: reverse the word, then rotate
  function automatic int perm_dst(input int i, input int w, input int rot);
    return (w - 1 - i + rot) % w;
  endfunction

endpackage

// File: rtl/addr_scr_sub.sv
module addr_scr_sub #(
  parameter int AW      = 14,
  parameter bit INVERSE = 1'b0
) (
  input  logic [AW-1:0] din,
  output logic [AW-1:0] dout
);
  import addr_scr_pkg::*;

  localparam int NIB = AW / 4;
  localparam int REM = AW % 4;

  for (genvar k = 0; k < NIB; k++) begin : g_nib
    if (INVERSE) begin : g_inv
      assign dout[4*k +: 4] = sbox4_inv(din[4*k +: 4]);
    end else begin : g_fwd
      assign dout[4*k +: 4] = sbox4(din[4*k +: 4]);
    end
  end

  // Top leftover bits: add/subtract one modulo 2^REM
  if (REM > 0) begin : g_rem
    if (INVERSE) begin : g_inv
      assign dout[AW-1 -: REM] = din[AW-1 -: REM] - REM'(1);
    end else begin : g_fwd
      assign dout[AW-1 -: REM] = din[AW-1 -: REM] + REM'(1);
    end
  end

endmodule

// File: rtl/addr_scr_perm.sv
module addr_scr_perm #(
  parameter int AW      = 14,
  parameter bit INVERSE = 1'b0
) (
  input  logic [AW-1:0] din,
  output logic [AW-1:0] dout
);
  import addr_scr_pkg::*;

  localparam int ROT = AW / 3 + 1;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    localparam int DST = perm_dst(i, AW, ROT);
    if (INVERSE) begin : g_inv
      assign dout[i] = din[DST];
    end else begin : g_fwd
      assign dout[DST] = din[i];
    end
  end

endmodule

// File: rtl/addr_scr_round.sv
module addr_scr_round #(
  parameter int AW      = 14,
  parameter bit INVERSE = 1'b0
) (
  input  logic [AW-1:0] din,
  input  logic [AW-1:0] tweak,
  output logic [AW-1:0] dout
);
  logic [AW-1:0] stage_a;
  logic [AW-1:0] stage_b;

  if (!INVERSE) begin : g_fwd
    // tweak, substitute, permute
    assign stage_a = din ^ tweak;
    addr_scr_sub  #(.AW(AW), .INVERSE(1'b0)) i_sub  (.din(stage_a), .dout(stage_b));
    addr_scr_perm #(.AW(AW), .INVERSE(1'b0)) i_perm (.din(stage_b), .dout(dout));
  end else begin : g_inv
    // unpermute, unsubstitute, untweak
    addr_scr_perm #(.AW(AW), .INVERSE(1'b1)) i_perm (.din(din), .dout(stage_a));
    addr_scr_sub  #(.AW(AW), .INVERSE(1'b1)) i_sub  (.din(stage_a), .dout(stage_b));
    assign dout = stage_b ^ tweak;
  end

endmodule

// File: rtl/addr_scrambler.sv
module addr_scrambler #(
  parameter int  DEPTH  = 16384,
  parameter int  ROUNDS = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int NW     = ((ROUNDS > 0) ? ROUNDS : 1) * AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [NW-1:0] nonce_i,
  input  logic          inverse_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] plain_addr_o
);

  if (ROUNDS > 0 && (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
    $error("DEPTH must be a power of two when ROUNDS > 0");
  end

  logic [AW-1:0] scr_d;

  if (ROUNDS > 0) begin : g_scr
    logic [AW-1:0] fwd_chain [ROUNDS+1];
    logic [AW-1:0] inv_chain [ROUNDS+1];

    assign fwd_chain[0] = addr_i;
    assign inv_chain[0] = addr_i;

    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
      // forward: round r uses slice r
      addr_scr_round #(.AW(AW), .INVERSE(1'b0)) i_fwd (
        .din   (fwd_chain[r]),
        .tweak (nonce_i[r*AW +: AW]),
        .dout  (fwd_chain[r+1])
      );
      // inverse: undo rounds last-first
      addr_scr_round #(.AW(AW), .INVERSE(1'b1)) i_inv (
        .din   (inv_chain[r]),
        .tweak (nonce_i[(ROUNDS-1-r)*AW +: AW]),
        .dout  (inv_chain[r+1])
      );
    end

    assign scr_d = inverse_i ? inv_chain[ROUNDS] : fwd_chain[ROUNDS];
  end else begin : g_bypass
    logic unused_bypass;
    assign unused_bypass = ^{nonce_i, inverse_i};
    assign scr_d = addr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o       <= '0;
      plain_addr_o <= '0;
    end else begin
      addr_o       <= scr_d;
      plain_addr_o <= addr_i;
    end
  end

endmodule

// File: rtl/addr_scrambler_chk.sv
module addr_scrambler_chk #(
  parameter int AW     = 14,
  parameter int NW     = 28,
  parameter int ROUNDS = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_i,
  input logic [NW-1:0] nonce_i,
  input logic          inverse_i,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] plain_addr_o
);
  logic       seen = 1'b0;
  logic [1:0] live;

  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (rst) live <= '0;
    else if (live != 2'd2) live <= live + 2'd1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    seen && $past(rst) |-> (addr_o == '0) && (plain_addr_o == '0));

  // R7
  plain_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (live != 2'd0) |-> plain_addr_o == $past(addr_i));

  // R2
  steady_in_chk: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd2) && $stable(addr_i) && $stable(nonce_i) && $stable(inverse_i)
    |=> $stable(addr_o));

  // R3
  distinct_out_chk: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd2) && !$stable(addr_i) && $stable(nonce_i) && $stable(inverse_i)
    |=> !$stable(addr_o));

  if (ROUNDS == 0) begin : g_bypass_chk
    // R6
    bypass_equal_chk: assert property (@(posedge clk) disable iff (rst)
      (live != 2'd0) |-> addr_o == plain_addr_o);
  end

endmodule

bind addr_scrambler addr_scrambler_chk #(.AW(AW), .NW(NW), .ROUNDS(ROUNDS)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .addr_i       (addr_i),
  .nonce_i      (nonce_i),
  .inverse_i    (inverse_i),
  .addr_o       (addr_o),
  .plain_addr_o (plain_addr_o)
);

// File: tb/test_addr_scrambler.sv
module test_addr_scrambler;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int AW     = 6;
  localparam int NW     = 12;
  localparam int BDEPTH = 32;
  localparam int BAW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0]  addr_i = '0;
  logic [NW-1:0]  nonce_i = '0;
  logic           inverse_i = 1'b0;
  logic [AW-1:0]  addr_o, plain_addr_o;

  logic [BAW-1:0] b_addr_i = '0;
  logic [BAW-1:0] b_nonce_i = '0;
  logic           b_inverse_i = 1'b0;
  logic [BAW-1:0] b_addr_o, b_plain_addr_o;

  addr_scrambler #(.DEPTH(DEPTH), .ROUNDS(2)) i_addr_scrambler (
    .clk(clk), .rst(rst), .addr_i(addr_i), .nonce_i(nonce_i),
    .inverse_i(inverse_i), .addr_o(addr_o), .plain_addr_o(plain_addr_o));

  addr_scrambler #(.DEPTH(BDEPTH), .ROUNDS(0)) i_addr_scrambler_bypass (
    .clk(clk), .rst(rst), .addr_i(b_addr_i), .nonce_i(b_nonce_i),
    .inverse_i(b_inverse_i), .addr_o(b_addr_o), .plain_addr_o(b_plain_addr_o));

  int n_checks = 0;
  int n_fail   = 0;
  logic [AW-1:0] map_a [DEPTH];
  logic [AW-1:0] map_b [DEPTH];

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  // drive at a falling edge, result sampled one falling edge later
  task automatic run(input logic [AW-1:0] a, input logic [NW-1:0] n,
                     input logic inv, output logic [AW-1:0] y);
    @(negedge clk);
    addr_i = a; nonce_i = n; inverse_i = inv;
    @(negedge clk);
    y = addr_o;
  endtask

  task automatic fill_map(input logic [NW-1:0] n, ref logic [AW-1:0] m [DEPTH]);
    for (int a = 0; a < DEPTH; a++) run(AW'(a), n, 1'b0, m[a]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; addr_i = 6'h2A; nonce_i = 12'hFFF; b_addr_i = 5'h13;
    @(negedge clk);
    @(negedge clk);
    check("R1 addr_o", int'(addr_o), 0);
    check("R1 plain_addr_o", int'(plain_addr_o), 0);
    check("R1 bypass addr_o", int'(b_addr_o), 0);
    rst = 1'b0;
  endtask

  task automatic t_bijection(input logic [NW-1:0] n);
    logic [DEPTH-1:0] seen;
    int distinct;
    logic [AW-1:0] back;
    seen = '0;
    distinct = 0;
    fill_map(n, map_a);
    for (int a = 0; a < DEPTH; a++) begin
      if (!seen[map_a[a]]) distinct++;
      seen[map_a[a]] = 1'b1;
    end
    check("R3 distinct outputs", distinct, DEPTH);
    for (int a = 0; a < DEPTH; a++) begin
      run(map_a[a], n, 1'b1, back);
      check("R5 inverse round trip", int'(back), a);
    end
  endtask

  task automatic t_nonce_diff(input string req, input logic [NW-1:0] n0,
                              input logic [NW-1:0] n1);
    int diffs;
    diffs = 0;
    fill_map(n0, map_a);
    fill_map(n1, map_b);
    for (int a = 0; a < DEPTH; a++) if (map_a[a] != map_b[a]) diffs++;
    check(req, int'(diffs != 0), 1);
  endtask

  task automatic t_latency();
    logic [AW-1:0] y0, y1;
    run(6'h11, 12'h3F1, 1'b0, y0);
    check("R7 plain after one edge", int'(plain_addr_o), 17);
    @(negedge clk);
    addr_i = 6'h22; inverse_i = 1'b1; nonce_i = 12'h777;
    @(negedge clk);
    check("R7 plain ignores mode and nonce", int'(plain_addr_o), 34);
    run(6'h11, 12'h3F1, 1'b0, y1);
    check("R2 repeatable result", int'(y1), int'(y0));
    // hold inputs: output must not move
    @(negedge clk);
    check("R2 held output", int'(addr_o), int'(y0));
  endtask

  task automatic t_bypass();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      b_addr_i = BAW'(k * 7 + 3); b_nonce_i = BAW'(k * 11 + 5); b_inverse_i = k[0];
      @(negedge clk);
      check("R6 bypass identity", int'(b_addr_o), (k * 7 + 3) % BDEPTH);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_latency();
    t_bijection(12'h000);
    t_bijection(12'hA5C);
    t_bijection(12'h3F1);
    // R4: first-round slices differ (0x00 vs 0x31)
    t_nonce_diff("R4 first slice changes map", 12'h000, 12'h3F1);
    // R8: only bits [11:6] differ
    t_nonce_diff("R8 last slice changes map", 12'hA5C, 12'h05C);
    t_bypass();
    summary();
  end

endmodule